// File: doc/BRIEF.md
# Flash Command Interface Read-Mode Controller

This block is the command front end and read-data selector of a 16-bit parallel NOR flash device. The host writes command bytes over the bus. Each command byte picks what later reads return: array data, the 8-bit status register, or words from a configuration space. That space holds the identifiers, the lock state of each block and a small protection register. The selected mode stays in force until another recognised command is written. Array contents, the program and erase algorithms and the write state machine lie outside the block. They reach it only as plain input ports.

The status register merges live flags from the write state machine with four sticky error flags. The state machine can set the error flags but never clear them, so errors collect across a series of operations until software writes the clear command. The bus sees a snapshot of the status register. The snapshot is taken when the bus read becomes active, which is when the later of chip-enable and output-enable goes low. It then stays frozen until the next activation, so a value cannot change while it is being read.

All bus pins are sampled on the system clock. The read word and its drive qualifier are registered, so they reflect the inputs sampled at the same clock edge.

Top module: `flash_rd_ctrl`

## Requirements
- R1: After reset the mode is array read, `dq_drive` is 0, all four error flags are clear and the status value is 80h.
- R2: A command is accepted on the clock edge where `we_n` is sampled high after having been low and `ce_n` is low. Byte FFh selects array read, 70h selects status read and 90h selects configuration read. The selected mode holds until another recognised command is accepted.
- R3: Any other byte, including 50h, leaves the mode unchanged. A `we_n` rise while `ce_n` is high is not a command.
- R4: In status mode the output word is {8'h00, status}. The status bit map is: bit 7 = `wsm_ready`, bit 6 = `wsm_susp_erase`, bit 5 = error flag 3, bit 4 = error flag 2, bit 3 = error flag 1, bit 2 = `wsm_susp_prog`, bit 1 = error flag 0, bit 0 = 0.
- R5: The status shown is the live value at the edge where the bus becomes active (both enables low, one of them not low at the previous edge). It then stays frozen for as long as the bus stays active, even if the live status changes.
- R6: A 1 on `wsm_err_set[i]` sets error flag i at that edge. Error flags are never cleared by the state-machine inputs.
- R7: An accepted 50h clears all four error flags. If `wsm_err_set[i]` is 1 at the same edge, flag i ends up set.
- R8: In configuration mode, address 0 reads 0089h and address 1 reads parameter `DEV_ID`.
- R9: In configuration mode, block offset 2 of block b (address = b·2^BLK_W + 2) reads {14'b0, `blk_lock[2b+1]`, `blk_lock[2b]`}. Bit 0 means locked and bit 1 means locked-down.
- R10: In configuration mode, address 80h reads `prot_lock`, and address 81h+k (k = 0..PR_WORDS-1) reads `prot_words[16k+15:16k]`.
- R11: Every other configuration address reads 0000h.
- R12: At each edge `dq_drive` becomes 1 exactly when `ce_n` and `oe_n` are both sampled low, and `dq_out` becomes the selected word. When not driving, `dq_out` is 0000h. In array mode the selected word is `arr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; command taken on its rise |
| addr | input | ADDR_W | Word address |
| din | input | 16 | Write data; command byte in bits 7:0 |
| arr_data | input | 16 | Behavioural array read data |
| wsm_ready | input | 1 | State machine ready (1) / busy (0) |
| wsm_susp_erase | input | 1 | Erase-suspended flag, live |
| wsm_susp_prog | input | 1 | Program-suspended flag, live |
| wsm_err_set | input | 4 | Per-flag set pulses for the sticky error flags |
| blk_lock | input | 2*NBLK | Per-block {locked-down, locked} pairs |
| prot_lock | input | 16 | Protection-register lock word |
| prot_words | input | 16*PR_WORDS | Protection-register words, word k in bits 16k+15:16k |
| dq_out | output | 16 | Registered read word |
| dq_drive | output | 1 | High when the data bus is driven; low means high impedance |

## Verification
A clear command and a state-machine error pulse can land on the same clock edge. The clear command should win for the flags that are not pulsed, and the pulse should win for the flag that is. The bench raises `wsm_err_set` in the very cycle in which `we_n` returns high with 50h on the bus. A later status read must then show only the pulsed flag. A second collision arises when an error pulse comes during an active status read. The bench pulses a flag while the read is held active and requires the shown byte to stay unchanged until output-enable is toggled.

// File: rtl/frc_pkg.sv
package frc_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_STATUS = 2'd1,
      RM_CONFIG = 2'd2
   } rmode_e;

   localparam int          DQ_W        = 16;
   localparam int          CMD_W       = 8;
   localparam int          ERR_N       = 4;
   localparam int          STAT_W      = 8;

   localparam logic [CMD_W-1:0] CMD_ARRAY   = 8'hFF;
   localparam logic [CMD_W-1:0] CMD_STATUS  = 8'h70;
   localparam logic [CMD_W-1:0] CMD_CONFIG  = 8'h90;
   localparam logic [CMD_W-1:0] CMD_CLRSTAT = 8'h50;

   localparam logic [DQ_W-1:0]  MFR_CODE    = 16'h0089;
   localparam int               OFF_MFR     = 0;
   localparam int               OFF_DEV     = 1;
   localparam int               OFF_LOCK    = 2;
   localparam int               OFF_PRLOCK  = 'h80;

endpackage

// File: rtl/frc_cmd_dec.sv
module frc_cmd_dec
   import frc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce_n,
   input  logic             we_n,
   input  logic [CMD_W-1:0] cmd_byte,
   output rmode_e           mode,
   output logic             cmd_strobe,
   output logic             clr_pulse
);

   logic   we_q;
   rmode_e mode_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end

   assign cmd_strobe = we_n & ~we_q & ~ce_n;
   assign clr_pulse  = cmd_strobe && (cmd_byte == CMD_CLRSTAT);

   always_comb begin
      mode_nx = mode;
      if (cmd_strobe) begin
         unique case (cmd_byte)
            CMD_ARRAY:  mode_nx = RM_ARRAY;
            CMD_STATUS: mode_nx = RM_STATUS;
            CMD_CONFIG: mode_nx = RM_CONFIG;
            default:    mode_nx = mode;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode <= RM_ARRAY;
      else        mode <= mode_nx;
   end

endmodule

// File: rtl/frc_status.sv
module frc_status
   import frc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wsm_ready,
   input  logic              wsm_susp_erase,
   input  logic              wsm_susp_prog,
   input  logic [ERR_N-1:0]  err_set,
   input  logic              clr,
   input  logic              bus_act,
   output logic [STAT_W-1:0] stat_shown,
   output logic [STAT_W-1:0] snap_q,
   output logic [ERR_N-1:0]  err_q,
   output logic              act_rise
);

   logic              act_q;
   logic [STAT_W-1:0] live;

   assign live = {wsm_ready, wsm_susp_erase, err_q[3], err_q[2],
                  err_q[1], wsm_susp_prog, err_q[0], 1'b0};

   assign act_rise   = bus_act & ~act_q;
   assign stat_shown = act_rise ? live : snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         err_q  <= '0;
         snap_q <= 8'h80;
      end else begin
         act_q  <= bus_act;
         err_q  <= (err_q & ~{ERR_N{clr}}) | err_set;
         if (act_rise) snap_q <= live;
      end
   end

endmodule

// File: rtl/frc_cfg.sv
module frc_cfg
   import frc_pkg::*;
#(
   parameter int              ADDR_W   = 12,
   parameter int              BLK_W    = 8,
   parameter int              PR_WORDS = 8,
   parameter logic [DQ_W-1:0] DEV_ID   = 16'h88C2,
   localparam int             NBLK     = 1 << (ADDR_W - BLK_W)
)(
   input  logic [ADDR_W-1:0]        addr,
   input  logic [2*NBLK-1:0]        blk_lock,
   input  logic [DQ_W-1:0]          prot_lock,
   input  logic [DQ_W*PR_WORDS-1:0] prot_words,
   output logic [DQ_W-1:0]          cfg_word
);

   localparam int BIDX_W = ADDR_W - BLK_W;

   logic [BLK_W-1:0]  off;
   logic [BIDX_W-1:0] bidx;
   logic [DQ_W-1:0]   lock_word [NBLK];
   logic [DQ_W-1:0]   pr_word   [PR_WORDS];
   logic              in_blk0;

   assign off     = addr[BLK_W-1:0];
   assign bidx    = addr[ADDR_W-1:BLK_W];
   assign in_blk0 = (bidx == '0);

   for (genvar b = 0; b < NBLK; b++) begin : g_lock
      assign lock_word[b] = {{(DQ_W-2){1'b0}}, blk_lock[2*b+1], blk_lock[2*b]};
   end

   for (genvar k = 0; k < PR_WORDS; k++) begin : g_pr
      assign pr_word[k] = prot_words[DQ_W*k +: DQ_W];
   end

   always_comb begin
      cfg_word = '0;
      if (off == BLK_W'(OFF_LOCK)) begin
         cfg_word = lock_word[bidx];
      end else if (in_blk0) begin
         if (off == BLK_W'(OFF_MFR)) begin
            cfg_word = MFR_CODE;
         end else if (off == BLK_W'(OFF_DEV)) begin
            cfg_word = DEV_ID;
         end else if (off == BLK_W'(OFF_PRLOCK)) begin
            cfg_word = prot_lock;
         end else begin
            for (int k = 0; k < PR_WORDS; k++) begin
               if (off == BLK_W'(OFF_PRLOCK + 1 + k)) cfg_word = pr_word[k];
            end
         end
      end
   end

endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
   import frc_pkg::*;
#(
   parameter int              ADDR_W   = 12,
   parameter int              BLK_W    = 8,
   parameter int              PR_WORDS = 8,
   parameter logic [DQ_W-1:0] DEV_ID   = 16'h88C2
)(
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               ce_n,
   input  logic                               oe_n,
   input  logic                               we_n,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [15:0]                        din,
   input  logic [15:0]                        arr_data,
   input  logic                               wsm_ready,
   input  logic                               wsm_susp_erase,
   input  logic                               wsm_susp_prog,
   input  logic [3:0]                         wsm_err_set,
   input  logic [2*(1<<(ADDR_W-BLK_W))-1:0]   blk_lock,
   input  logic [15:0]                        prot_lock,
   input  logic [16*PR_WORDS-1:0]             prot_words,
   output logic [15:0]                        dq_out,
   output logic                               dq_drive
);

   initial begin
      assert (BLK_W >= 8)
         else $error("BLK_W must reach the protection offsets");
      assert (ADDR_W > BLK_W)
         else $error("ADDR_W must exceed BLK_W");
      assert (PR_WORDS >= 1 && OFF_PRLOCK + PR_WORDS < (1 << BLK_W))
         else $error("PR_WORDS does not fit in one block");
   end

   rmode_e            mode_q;
   logic              cmd_strobe;
   logic              clr_pulse;
   logic              bus_act;
   logic              act_rise;
   logic [STAT_W-1:0] stat_shown;
   logic [STAT_W-1:0] snap_q;
   logic [ERR_N-1:0]  err_q;
   logic [DQ_W-1:0]   cfg_word;
   logic [DQ_W-1:0]   rd_word;

   assign bus_act = ~ce_n & ~oe_n;

   frc_cmd_dec u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_n       (ce_n),
      .we_n       (we_n),
      .cmd_byte   (din[CMD_W-1:0]),
      .mode       (mode_q),
      .cmd_strobe (cmd_strobe),
      .clr_pulse  (clr_pulse)
   );

   frc_status u_stat (
      .clk            (clk),
      .rst_n          (rst_n),
      .wsm_ready      (wsm_ready),
      .wsm_susp_erase (wsm_susp_erase),
      .wsm_susp_prog  (wsm_susp_prog),
      .err_set        (wsm_err_set),
      .clr            (clr_pulse),
      .bus_act        (bus_act),
      .stat_shown     (stat_shown),
      .snap_q         (snap_q),
      .err_q          (err_q),
      .act_rise       (act_rise)
   );

   frc_cfg #(
      .ADDR_W   (ADDR_W),
      .BLK_W    (BLK_W),
      .PR_WORDS (PR_WORDS),
      .DEV_ID   (DEV_ID)
   ) u_cfg (
      .addr       (addr),
      .blk_lock   (blk_lock),
      .prot_lock  (prot_lock),
      .prot_words (prot_words),
      .cfg_word   (cfg_word)
   );

   always_comb begin
      unique case (mode_q)
         RM_STATUS: rd_word = {{(DQ_W-STAT_W){1'b0}}, stat_shown};
         RM_CONFIG: rd_word = cfg_word;
         default:   rd_word = arr_data;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dq_drive <= 1'b0;
         dq_out   <= '0;
      end else begin
         dq_drive <= bus_act;
         dq_out   <= bus_act ? rd_word : '0;
      end
   end

endmodule

// File: rtl/frc_chk.sv
module frc_chk
   import frc_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic [7:0]        cmd_byte,
   input rmode_e            mode_q,
   input logic              cmd_strobe,
   input logic              clr_pulse,
   input logic              act_rise,
   input logic [STAT_W-1:0] snap_q,
   input logic [ERR_N-1:0]  err_q,
   input logic [15:0]       dq_out,
   input logic              dq_drive
);

   // R12
   drive_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n) |=> dq_drive);

   // R12
   drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |=> (!dq_drive && dq_out == 16'h0000));

   // R4
   stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == RM_STATUS && !ce_n && !oe_n) |=> (dq_out[15:8] == 8'h00));

   // R3
   unknown_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_strobe && cmd_byte != CMD_ARRAY && cmd_byte != CMD_STATUS &&
       cmd_byte != CMD_CONFIG) |=> $stable(mode_q));

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_pulse |=> ((err_q & $past(err_q)) == $past(err_q)));

   // R5
   snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act_rise |=> $stable(snap_q));

endmodule

bind flash_rd_ctrl frc_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ce_n       (ce_n),
   .oe_n       (oe_n),
   .cmd_byte   (din[7:0]),
   .mode_q     (mode_q),
   .cmd_strobe (cmd_strobe),
   .clr_pulse  (clr_pulse),
   .act_rise   (act_rise),
   .snap_q     (snap_q),
   .err_q      (err_q),
   .dq_out     (dq_out),
   .dq_drive   (dq_drive)
);

// File: tb/sim_flash_rd_ctrl.sv
module sim_flash_rd_ctrl;

   localparam int CLK_T    = 10;
   localparam int ADDR_W   = 12;
   localparam int BLK_W    = 8;
   localparam int PR_WORDS = 8;
   localparam int NBLK     = 1 << (ADDR_W - BLK_W);
   localparam logic [15:0] DEV_ID = 16'h88C2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [15:0] din = '0;
   logic [15:0] arr_data = '0;
   logic wsm_ready = 1'b1, wsm_susp_erase = 1'b0, wsm_susp_prog = 1'b0;
   logic [3:0] wsm_err_set = '0;
   logic [2*NBLK-1:0] blk_lock = 32'h9C63_2D4B;
   logic [15:0] prot_lock = 16'hFFFD;
   logic [16*PR_WORDS-1:0] prot_words;
   logic [15:0] dq_out;
   logic dq_drive;

   always #(CLK_T/2) clk = ~clk;

   flash_rd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PR_WORDS(PR_WORDS),
                   .DEV_ID(DEV_ID)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .arr_data(arr_data), .wsm_ready(wsm_ready),
      .wsm_susp_erase(wsm_susp_erase), .wsm_susp_prog(wsm_susp_prog),
      .wsm_err_set(wsm_err_set), .blk_lock(blk_lock), .prot_lock(prot_lock),
      .prot_words(prot_words), .dq_out(dq_out), .dq_drive(dq_drive));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   string tag = "R1";

   // reference model state: 0 array, 1 status, 2 config
   int         m_mode = 0;
   logic [3:0] m_err = '0;
   logic [7:0] m_snap = 8'h80;
   logic       m_act_q = 0;
   logic       m_we_q = 1;
   logic [15:0] exp_out = '0;
   logic       exp_drive = 0;

   task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] cfg_exp(input logic [ADDR_W-1:0] a);
      int blk, off;
      blk = int'(a) / 256;
      off = int'(a) % 256;
      if (off == 2) return {14'b0, blk_lock[2*blk+1], blk_lock[2*blk]};
      if (blk != 0) return 16'h0000;
      if (off == 0) return 16'h0089;
      if (off == 1) return DEV_ID;
      if (off == 'h80) return prot_lock;
      if (off >= 'h81 && off < 'h81 + PR_WORDS) return prot_words[16*(off-'h81) +: 16];
      return 16'h0000;
   endfunction

   always @(posedge clk) begin
      logic [7:0] live;
      logic act, rise;
      logic [15:0] word;
      if (!rst_n) begin
         m_mode = 0; m_err = '0; m_snap = 8'h80; m_act_q = 0; m_we_q = 1;
         exp_out = '0; exp_drive = 0;
      end else begin
         live = {wsm_ready, wsm_susp_erase, m_err[3], m_err[2], m_err[1],
                 wsm_susp_prog, m_err[0], 1'b0};
         act  = !ce_n && !oe_n;
         rise = act && !m_act_q;
         if (m_mode == 1)      word = {8'h00, rise ? live : m_snap};
         else if (m_mode == 2) word = cfg_exp(addr);
         else                  word = arr_data;
         exp_drive = act;
         exp_out   = act ? word : 16'h0000;
         if (rise) m_snap = live;
         if (we_n && !m_we_q && !ce_n) begin
            if (din[7:0] == 8'h50) m_err = '0;
            if (din[7:0] == 8'hFF) m_mode = 0;
            if (din[7:0] == 8'h70) m_mode = 1;
            if (din[7:0] == 8'h90) m_mode = 2;
         end
         m_err = m_err | wsm_err_set;
         m_act_q = act;
         m_we_q = we_n;
      end
   end

   always @(posedge clk) begin
      #2;
      if (rst_n && !done) check(tag, {dq_drive, dq_out}, {exp_drive, exp_out});
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ce_n = 1; oe_n = 1; we_n = 1; wsm_err_set = '0;
      end
   endtask

   task automatic write_cmd(input logic [7:0] b, input logic [3:0] err_same);
      @(negedge clk); ce_n = 0; oe_n = 1; we_n = 0; din = {8'h00, b};
      @(negedge clk); we_n = 1; wsm_err_set = err_same;
      @(negedge clk); ce_n = 1; wsm_err_set = '0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
      end
      @(negedge clk); oe_n = 1; ce_n = 1;
   endtask

   task automatic pulse_err(input logic [3:0] e);
      @(negedge clk); wsm_err_set = e;
      @(negedge clk); wsm_err_set = '0;
   endtask

   initial begin
      for (int k = 0; k < PR_WORDS; k++) prot_words[16*k +: 16] = 16'hA500 + 16'(k * 'h111);
      #(CLK_T * 3 + 1);
      check("R1", {16'h0, dq_drive}, 17'h0);
      rst_n = 1;
      idle(2);
      tag = "R1"; write_cmd(8'h70, 0); rd('0, 2);
      tag = "R12"; write_cmd(8'hFF, 0);
      arr_data = 16'h1234; rd(12'h010, 1);
      arr_data = 16'hBEEF; rd(12'h011, 3);
      @(negedge clk); ce_n = 0; oe_n = 1; @(negedge clk); ce_n = 1; oe_n = 0;
      @(negedge clk); oe_n = 1;
      tag = "R2"; write_cmd(8'h90, 0); rd(12'h000, 1); idle(3); rd(12'h001, 1);
      tag = "R3"; write_cmd(8'h12, 0); rd(12'h000, 1);
      write_cmd(8'h50, 0); rd(12'h001, 1);
      @(negedge clk); ce_n = 1; we_n = 0; din = 16'h00FF;
      @(negedge clk); we_n = 1; rd(12'h001, 1);
      tag = "R8"; rd(12'h000, 2); rd(12'h001, 2);
      tag = "R9";
      for (int b = 0; b < NBLK; b++) rd(ADDR_W'(b * 256 + 2), 1);
      tag = "R10"; rd(12'h080, 1);
      for (int k = 0; k < PR_WORDS; k++) rd(ADDR_W'('h81 + k), 1);
      tag = "R11"; rd(12'h003, 1); rd(12'h089, 1); rd(12'h07F, 1);
      rd(12'h100, 1); rd(12'h181, 1); rd(12'h0FF, 1);
      tag = "R4"; write_cmd(8'h70, 0);
      wsm_ready = 0; wsm_susp_erase = 1; rd('0, 2);
      wsm_ready = 1; wsm_susp_erase = 0; wsm_susp_prog = 1; rd('0, 2);
      wsm_susp_prog = 0;
      tag = "R6";
      for (int i = 0; i < 4; i++) begin
         pulse_err(4'(1 << i)); idle(1); rd('0, 1);
      end
      idle(4); rd('0, 2);
      tag = "R7"; write_cmd(8'h50, 0); rd('0, 1);
      pulse_err(4'b1011); rd('0, 1);
      write_cmd(8'h50, 4'b0100); rd('0, 2);
      tag = "R5";
      @(negedge clk); ce_n = 0; oe_n = 0;
      @(negedge clk); wsm_err_set = 4'b0001;
      @(negedge clk); wsm_err_set = 0; wsm_ready = 0;
      @(negedge clk); @(negedge clk); oe_n = 1;
      @(negedge clk); oe_n = 0;
      @(negedge clk); @(negedge clk); ce_n = 1; oe_n = 1; wsm_ready = 1;
      @(negedge clk); oe_n = 0; @(negedge clk); ce_n = 0;
      @(negedge clk); @(negedge clk); ce_n = 1; oe_n = 1;
      tag = "R2"; write_cmd(8'hFF, 0); arr_data = 16'h5A5A; rd('0, 2);
      idle(3);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(CLK_T * 100000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule